// File: doc/BRIEF.md
# USB Endpoint Stall and Transmit Data-Present Control

This block is the register unit for the stall and data-present state of a four-endpoint USB function controller. It follows write and packet-enable events on each transmit FIFO, and clears the matching flag once the FIFO has been drained to the host. It exposes these flags as a read-only status byte. A second byte holds one stall bit per endpoint. Software writes this byte, and each bit drives the stall request to that endpoint's handshake generator.

Endpoint 0 has its own stall rules around control transfers. When the protocol engine receives a setup command that the function decodes itself, the endpoint 0 stall bit clears without any software action. While the setup-received flag is up, software cannot set that bit. Software can still change the stall bits of the other endpoints.

Access goes through a small 8-bit register port with address, write enable, write data and combinational read data. The event strobes are one cycle wide.

Top module: `usb_ep_ctl`

## Requirements
- R1: After reset, both the status byte and the stall byte read 0x00 and every stall_req bit is 0.
- R2: The status byte, read at address 0, carries the data-present flag of transmit index 2 (endpoint 3) at bit 5, index 1 (endpoint 2) at bit 4 and index 0 (endpoint 0 IN) at bit 0. Bits 7, 6 and 3 to 1 read 0.
- R3: A data-present flag sets in the cycle after a tx_pkt_en pulse for that endpoint, provided a tx_fifo_wr pulse arrived since its last promotion or in the same cycle. A tx_pkt_en pulse without such a write has no effect.
- R4: A data-present flag clears in the cycle after a tx_done pulse for that endpoint.
- R5: If a promoting tx_pkt_en and a tx_done arrive for the same endpoint in the same cycle, the flag ends up set.
- R6: Writes to the status address leave the status byte unchanged.
- R7: The stall byte, at address 1, holds endpoint n's stall bit at bit n for n = 0..3. Bits 7 to 4 read 0 and ignore written values.
- R8: stall_req[n] equals stall bit n. A write becomes visible on stall_req in the cycle after the write.
- R9: A setup_cmd pulse clears the endpoint 0 stall bit in the next cycle, even if a write to the stall byte happens in the same cycle.
- R10: While setup_flag is 1, a stall write with bit 0 set leaves endpoint 0's stall bit unchanged, while bits 3 to 1 take the written value. A write with bit 0 clear still clears endpoint 0's stall.
- R11: Reads from any address other than 0 and 1 return 0x00, and writes to them change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_addr | input | 4 | Register address |
| reg_we | input | 1 | Register write enable |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data (combinational) |
| tx_fifo_wr | input | 3 | Per transmit endpoint: FIFO was written |
| tx_pkt_en | input | 3 | Per transmit endpoint: packet enabled |
| tx_done | input | 3 | Per transmit endpoint: all data sent to host |
| setup_flag | input | 1 | Setup-received flag (level) |
| setup_cmd | input | 1 | Self-decoded setup command received (pulse) |
| stall_req | output | 4 | Stall request per endpoint to handshake generator |

## Verification
The bench targets same-cycle collisions. A promote that coincides with a done must leave the flag set; a design with the wrong priority would drop a freshly enabled packet. A setup command that coincides with a stall write must clear endpoint 0; if it did not, the endpoint would stay stalled after a control setup. The bench also issues guarded stall writes while the setup flag is up. A design that applied the guard to every bit would lose stalls on endpoints 1 to 3. A design that ignored the guard would stall endpoint 0 in the middle of a setup. It also checks packet enables that have no preceding FIFO write, which must not raise a flag, and reserved bits that are written as ones.

// File: rtl/usb_ep_ctl_pkg.sv
package usb_ep_ctl_pkg;
   typedef enum logic [1:0] {
      SEL_NONE  = 2'd0,
      SEL_STAT  = 2'd1,
      SEL_STALL = 2'd2
   } regsel_e;

   localparam int unsigned BYTE_W = 8;
endpackage

// File: rtl/usb_ep_dp_track.sv
module usb_ep_dp_track (
   input  logic clk,
   input  logic rst_n,
   input  logic fifo_wr,
   input  logic pkt_en,
   input  logic done,
   output logic present
);
   logic pend_q;
   logic promote;

   assign promote = pkt_en & (pend_q | fifo_wr);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pend_q  <= 1'b0;
         present <= 1'b0;
      end else begin
         pend_q <= promote ? 1'b0 : (pend_q | fifo_wr);
         if (promote)
            present <= 1'b1;
         else if (done)
            present <= 1'b0;
      end
   end

   assert_set_R3 : assert property (@(posedge clk) disable iff (!rst_n)
      (pkt_en && (pend_q || fifo_wr)) |=> present);
   assert_clear_R4 : assert property (@(posedge clk) disable iff (!rst_n)
      (done && !pkt_en) |=> !present);
   assert_set_wins_R5 : assert property (@(posedge clk) disable iff (!rst_n)
      (done && pkt_en && (pend_q || fifo_wr)) |=> present);
   assert_no_spurious_R3 : assert property (@(posedge clk) disable iff (!rst_n)
      (!present && !pkt_en) |=> !present);
endmodule

// File: rtl/usb_ep_stall_bank.sv
module usb_ep_stall_bank #(
   parameter int unsigned NUM_EP = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [NUM_EP-1:0] wdata,
   input  logic              setup_flag,
   input  logic              setup_cmd,
   output logic [NUM_EP-1:0] stall
);
   logic [NUM_EP-1:0] stall_d;

   always_comb begin
      stall_d = stall;
      if (wr_en) begin
         stall_d = wdata;
         if (setup_flag && wdata[0])
            stall_d[0] = stall[0];
      end
      if (setup_cmd)
         stall_d[0] = 1'b0;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         stall <= '0;
      else
         stall <= stall_d;
   end

   assert_auto_clear_R9 : assert property (@(posedge clk) disable iff (!rst_n)
      setup_cmd |=> !stall[0]);
   assert_guard_R10 : assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && setup_flag && wdata[0] && !setup_cmd) |=> $stable(stall[0]));
   assert_others_R10 : assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |=> (stall[NUM_EP-1:1] == $past(wdata[NUM_EP-1:1])));
   assert_hold_R8 : assert property (@(posedge clk) disable iff (!rst_n)
      (!wr_en && !setup_cmd) |=> $stable(stall));
endmodule

// File: rtl/usb_ep_rd_mux.sv
module usb_ep_rd_mux
   import usb_ep_ctl_pkg::*;
(
   input  regsel_e           sel,
   input  logic [BYTE_W-1:0] stat_byte,
   input  logic [BYTE_W-1:0] stall_byte,
   output logic [BYTE_W-1:0] rdata
);
   always_comb begin
      unique case (sel)
         SEL_STAT:  rdata = stat_byte;
         SEL_STALL: rdata = stall_byte;
         default:   rdata = '0;
      endcase
   end
endmodule

// File: rtl/usb_ep_ctl.sv
module usb_ep_ctl
   import usb_ep_ctl_pkg::*;
#(
   parameter int unsigned ADDR_W     = 4,
   parameter int unsigned NUM_EP     = 4,
   parameter int unsigned NUM_TX     = 3,
   parameter logic [ADDR_W-1:0] STAT_ADDR  = 4'h0,
   parameter logic [ADDR_W-1:0] STALL_ADDR = 4'h1,
   parameter logic [NUM_TX*3-1:0] TX_BITPOS = {3'd5, 3'd4, 3'd0}
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] reg_addr,
   input  logic              reg_we,
   input  logic [7:0]        reg_wdata,
   output logic [7:0]        reg_rdata,
   input  logic [NUM_TX-1:0] tx_fifo_wr,
   input  logic [NUM_TX-1:0] tx_pkt_en,
   input  logic [NUM_TX-1:0] tx_done,
   input  logic              setup_flag,
   input  logic              setup_cmd,
   output logic [NUM_EP-1:0] stall_req
);
   localparam int unsigned RSV_W = BYTE_W - NUM_EP;

   generate
      if (NUM_EP < 1 || NUM_EP > BYTE_W) begin : g_bad_ep
         $error("NUM_EP must be 1..8");
      end
      if (NUM_TX < 1 || NUM_TX > BYTE_W) begin : g_bad_tx
         $error("NUM_TX must be 1..8");
      end
      if (STAT_ADDR == STALL_ADDR) begin : g_bad_addr
         $error("register addresses must differ");
      end
   endgenerate

   regsel_e           sel;
   logic [NUM_TX-1:0] present;
   logic [NUM_EP-1:0] stall_q;
   logic [BYTE_W-1:0] stat_byte;
   logic [BYTE_W-1:0] stall_byte;
   logic              stall_wr;
   logic              unused_wdata;

   assign unused_wdata = ^reg_wdata[BYTE_W-1:NUM_EP];

   always_comb begin
      if (reg_addr == STAT_ADDR)
         sel = SEL_STAT;
      else if (reg_addr == STALL_ADDR)
         sel = SEL_STALL;
      else
         sel = SEL_NONE;
   end

   assign stall_wr = reg_we && (sel == SEL_STALL);

   genvar gi;
   generate
      for (gi = 0; gi < NUM_TX; gi++) begin : g_tx
         usb_ep_dp_track u_trk (
            .clk     (clk),
            .rst_n   (rst_n),
            .fifo_wr (tx_fifo_wr[gi]),
            .pkt_en  (tx_pkt_en[gi]),
            .done    (tx_done[gi]),
            .present (present[gi])
         );
      end
   endgenerate

   always_comb begin
      stat_byte = '0;
      for (int i = 0; i < NUM_TX; i++)
         stat_byte[TX_BITPOS[i*3 +: 3]] = present[i];
   end

   usb_ep_stall_bank #(.NUM_EP(NUM_EP)) u_stall (
      .clk        (clk),
      .rst_n      (rst_n),
      .wr_en      (stall_wr),
      .wdata      (reg_wdata[NUM_EP-1:0]),
      .setup_flag (setup_flag),
      .setup_cmd  (setup_cmd),
      .stall      (stall_q)
   );

   generate
      if (RSV_W > 0) begin : g_pad
         assign stall_byte = {{RSV_W{1'b0}}, stall_q};
      end else begin : g_nopad
         assign stall_byte = stall_q;
      end
   endgenerate

   assign stall_req = stall_q;

   usb_ep_rd_mux u_rd (
      .sel        (sel),
      .stat_byte  (stat_byte),
      .stall_byte (stall_byte),
      .rdata      (reg_rdata)
   );

   assert_stall_rsvd_R7 : assert property (@(posedge clk) disable iff (!rst_n)
      (reg_addr == STALL_ADDR) |-> (reg_rdata[BYTE_W-1:NUM_EP] == '0));
   assert_stat_ro_R6 : assert property (@(posedge clk) disable iff (!rst_n)
      (reg_we && reg_addr == STAT_ADDR && tx_pkt_en == '0 && tx_done == '0)
         |=> $stable(present));
   assert_other_addr_R11 : assert property (@(posedge clk) disable iff (!rst_n)
      (reg_addr != STAT_ADDR && reg_addr != STALL_ADDR) |-> (reg_rdata == '0));
   assert_stall_track_R8 : assert property (@(posedge clk) disable iff (!rst_n)
      (reg_we && reg_addr == STALL_ADDR && !setup_flag && !setup_cmd)
         |=> (stall_req == $past(reg_wdata[NUM_EP-1:0])));
endmodule

// File: tb/usb_ep_ctl_test.sv
module usb_ep_ctl_test;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [3:0] reg_addr = '0;
   logic       reg_we = 1'b0;
   logic [7:0] reg_wdata = '0;
   logic [7:0] reg_rdata;
   logic [2:0] tx_fifo_wr = '0;
   logic [2:0] tx_pkt_en = '0;
   logic [2:0] tx_done = '0;
   logic       setup_flag = 1'b0;
   logic       setup_cmd = 1'b0;
   logic [3:0] stall_req;

   int vectors = 0;
   int fails = 0;
   int cycles = 0;
   bit finished = 0;

   // behavioural reference state
   bit pend[3];
   bit pres[3];
   bit stl[4];

   always #4 clk = ~clk;

   usb_ep_ctl uut (
      .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_we(reg_we),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .tx_fifo_wr(tx_fifo_wr),
      .tx_pkt_en(tx_pkt_en), .tx_done(tx_done), .setup_flag(setup_flag),
      .setup_cmd(setup_cmd), .stall_req(stall_req)
   );

   function automatic logic [7:0] model_read(input logic [3:0] a);
      logic [7:0] v = 8'h00;
      if (a == 4'h0) begin
         v[5] = pres[2]; v[4] = pres[1]; v[0] = pres[0];
      end else if (a == 4'h1) begin
         for (int k = 0; k < 4; k++) v[k] = stl[k];
      end
      return v;
   endfunction

   function automatic logic [3:0] model_stall();
      logic [3:0] v;
      for (int k = 0; k < 4; k++) v[k] = stl[k];
      return v;
   endfunction

   task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
      vectors++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: actual %02h expected %02h at cycle %0d", req, act, exp, cycles);
      end
   endtask

   task automatic model_step();
      for (int i = 0; i < 3; i++) begin
         bit promote = tx_pkt_en[i] && (pend[i] || tx_fifo_wr[i]);
         if (promote) pres[i] = 1;
         else if (tx_done[i]) pres[i] = 0;
         pend[i] = promote ? 0 : (pend[i] || tx_fifo_wr[i]);
      end
      if (reg_we && reg_addr == 4'h1) begin
         for (int k = 1; k < 4; k++) stl[k] = reg_wdata[k];
         if (!(setup_flag && reg_wdata[0])) stl[0] = reg_wdata[0];
      end
      if (setup_cmd) stl[0] = 0;
   endtask

   // one clock: drive, compare, advance model
   task automatic tick(input string req, input logic [3:0] a, input logic we,
                       input logic [7:0] wd, input logic [2:0] wr,
                       input logic [2:0] pe, input logic [2:0] dn,
                       input logic sf, input logic sc);
      reg_addr = a; reg_we = we; reg_wdata = wd;
      tx_fifo_wr = wr; tx_pkt_en = pe; tx_done = dn;
      setup_flag = sf; setup_cmd = sc;
      #1;
      check(req, reg_rdata, model_read(a));
      check("R8", {4'h0, stall_req}, {4'h0, model_stall()});
      @(posedge clk);
      model_step();
      @(negedge clk);
   endtask

   always @(posedge clk) begin
      cycles++;
      if (cycles > 200000 && !finished) begin
         fails++;
         $display("FAIL watchdog: actual %0d expected <200000 cycles", cycles);
         $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
         $finish;
      end
   end

   initial begin
      for (int i = 0; i < 3; i++) begin pend[i] = 0; pres[i] = 0; end
      for (int k = 0; k < 4; k++) stl[k] = 0;
      repeat (2) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      tick("R1", 4'h0, 0, 8'h00, 3'b0, 3'b0, 3'b0, 0, 0);
      tick("R1", 4'h1, 0, 8'h00, 3'b0, 3'b0, 3'b0, 0, 0);
      // R3 pkt_en without write: no effect
      tick("R3", 4'h0, 0, 8'h00, 3'b0, 3'b111, 3'b0, 0, 0);
      tick("R3", 4'h0, 0, 8'h00, 3'b0, 3'b0, 3'b0, 0, 0);
      // R3 write then enable; R2 bit placement
      tick("R3", 4'h0, 0, 8'h00, 3'b001, 3'b0, 3'b0, 0, 0);
      tick("R3", 4'h0, 0, 8'h00, 3'b0, 3'b001, 3'b0, 0, 0);
      tick("R2", 4'h0, 0, 8'h00, 3'b110, 3'b110, 3'b0, 0, 0);
      tick("R2", 4'h0, 0, 8'h00, 3'b0, 3'b0, 3'b0, 0, 0);
      // R6 write to status ignored
      tick("R6", 4'h0, 1, 8'h00, 3'b0, 3'b0, 3'b0, 0, 0);
      tick("R6", 4'h0, 1, 8'hFF, 3'b0, 3'b0, 3'b0, 0, 0);
      // R4 clear on done
      tick("R4", 4'h0, 0, 8'h00, 3'b0, 3'b0, 3'b010, 0, 0);
      tick("R4", 4'h0, 0, 8'h00, 3'b0, 3'b0, 3'b0, 0, 0);
      // R5 set beats clear
      tick("R5", 4'h0, 0, 8'h00, 3'b111, 3'b111, 3'b111, 0, 0);
      tick("R5", 4'h0, 0, 8'h00, 3'b0, 3'b0, 3'b0, 0, 0);
      // R7 reserved stall bits; R8 stall_req follows
      tick("R7", 4'h1, 1, 8'hFF, 3'b0, 3'b0, 3'b0, 0, 0);
      tick("R7", 4'h1, 0, 8'h00, 3'b0, 3'b0, 3'b0, 0, 0);
      tick("R8", 4'h1, 1, 8'h0A, 3'b0, 3'b0, 3'b0, 0, 0);
      tick("R8", 4'h1, 0, 8'h00, 3'b0, 3'b0, 3'b0, 0, 0);
      // R10 guard on EP0 while setup flag up
      tick("R10", 4'h1, 1, 8'h05, 3'b0, 3'b0, 3'b0, 1, 0);
      tick("R10", 4'h1, 1, 8'h01, 3'b0, 3'b0, 3'b0, 0, 0);
      tick("R10", 4'h1, 1, 8'h0E, 3'b0, 3'b0, 3'b0, 1, 0);
      tick("R10", 4'h1, 0, 8'h00, 3'b0, 3'b0, 3'b0, 1, 0);
      // R9 auto clear beats same-cycle write
      tick("R9", 4'h1, 1, 8'h0F, 3'b0, 3'b0, 3'b0, 0, 0);
      tick("R9", 4'h1, 1, 8'h0F, 3'b0, 3'b0, 3'b0, 0, 1);
      tick("R9", 4'h1, 0, 8'h00, 3'b0, 3'b0, 3'b0, 0, 0);
      // R11 other addresses
      tick("R11", 4'h7, 1, 8'hFF, 3'b0, 3'b0, 3'b0, 0, 0);
      tick("R11", 4'hF, 0, 8'h00, 3'b0, 3'b0, 3'b0, 0, 0);
      tick("R7", 4'h1, 0, 8'h00, 3'b0, 3'b0, 3'b0, 0, 0);
      // mixed random traffic against the model
      for (int n = 0; n < 3000; n++) begin
         logic [3:0] a = 4'($urandom_range(0, 3));
         string rq = (a == 4'h0) ? "R2" : (a == 4'h1) ? "R7" : "R11";
         tick(rq, a, 1'($urandom), 8'($urandom), 3'($urandom), 3'($urandom),
              3'($urandom), 1'($urandom), ($urandom_range(0, 7) == 0));
      end
      finished = 1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
   end
endmodule